// File: doc/BRIEF.md
# USB Micro-frame Index Counter

This block keeps the 14-bit frame index of a high-speed USB controller. The low three bits count 125 us micro-frames inside a 1 ms frame, and the upper eleven bits carry the frame number. In the host role the index runs freely: it advances by one on each micro-frame tick while the controller runs. It also exposes the slice of bits that addresses the periodic frame list. The length of that list is chosen by a 3-bit size selector. When that slice wraps, the block raises a one-cycle rollover pulse.

In the device role the index cannot be written. It follows the frame numbers of received SOF tokens. A received number that differs from the stored frame number is reloaded with the micro-frame bits cleared. A matching number only steps the micro-frame bits. Software reaches the index through a 32-bit register-style write port. A write takes effect only when the host is halted, is not running, and all four byte strobes are set.

The SOF input is a valid-only stream: `sof_valid` qualifies `sof_frame` for one cycle. There is no back-pressure, because the block consumes a token in the same cycle it arrives. The micro-frame tick and the register write are plain pulses, and every output is a registered level or pulse.

Top module: `usb_frame_index`

## Requirements
- R1: While `rst_n` is low, and after its release, `frindex` is 0 and `rollover` is 0.
- R2: In host mode (`device_mode`=0), a cycle with `run`=1 and `uframe_tick`=1 increments `frindex` by one, modulo 2^14, in the next cycle.
- R3: `list_index` equals `frindex[N:3]`, zero-extended to 10 bits, where N = 12 - `list_size`. Codes 0..7 select 1024, 512, 256, 128, 64, 32, 16 and 8 entries.
- R4: `rollover` is high for exactly the one cycle after a host-mode tick advance in which `frindex[N:0]` was all ones; otherwise it is low.
- R5: In host mode, a write with `wr_en`=1, `wr_strb`=4'b1111, `halted`=1 and `run`=0 loads `wr_data[13:0]` into `frindex` in the next cycle.
- R6: A host write with `run`=1 or `halted`=0 leaves `frindex` unchanged by the write.
- R7: A write with `wr_strb` other than 4'b1111 leaves `frindex` unchanged.
- R8: In device mode, writes and micro-frame ticks have no effect; without `sof_valid` the index holds.
- R9: In device mode, an SOF whose `sof_frame` differs from `frindex[13:3]` sets `frindex` to {`sof_frame`, 3'b000} in the next cycle.
- R10: In device mode, an SOF whose `sof_frame` equals `frindex[13:3]` increments `frindex[2:0]` modulo 8 without touching bits [13:3].
- R11: `sof_frame_out` always equals `frindex[13:3]`, so a write also changes the frame number used for generated SOF tokens.
- R12: In host mode `sof_valid` is ignored, and with `run`=0 ticks are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| device_mode | input | 1 | 1 = device role, 0 = host role |
| run | input | 1 | Host run control |
| halted | input | 1 | Host reports halted |
| list_size | input | 3 | Periodic list size code (0 = 1024 ... 7 = 8 entries) |
| uframe_tick | input | 1 | One-cycle pulse per 125 us micro-frame |
| sof_valid | input | 1 | Received SOF token valid (no back-pressure) |
| sof_frame | input | 11 | Frame number of the received SOF |
| wr_en | input | 1 | Register write request |
| wr_strb | input | 4 | Byte strobes of the write |
| wr_data | input | 32 | Write data; bits [13:0] are used |
| frindex | output | 14 | Current frame index |
| list_index | output | 10 | Periodic frame list index |
| rollover | output | 1 | One-cycle frame-list rollover pulse |
| sof_frame_out | output | 11 | Frame number for generated SOF tokens |

## Verification
In the host role, a register write and a micro-frame tick can arrive in the same cycle. Only one of them may change the index: the run bit selects which. The random phases drive ticks, full and partial writes, and halted/run combinations together. Each cycle the bench computes from the requirements whether the write or the tick applies, and compares the index with that result. In the device role, a write or a tick can coincide with an SOF token. The SOF tokens are made to match the held frame number about half the time, and the bench checks that only the SOF decision shows.

// File: rtl/ufi_pkg.sv
package ufi_pkg;
  localparam int IDX_W    = 14;
  localparam int UF_W     = 3;
  localparam int FRAME_W  = IDX_W - UF_W;
  localparam int SIZE_W   = 3;
  localparam int LIST_W   = 10;
  localparam int BUS_W    = 32;
  localparam int STRB_W   = BUS_W / 8;

  typedef enum logic [2:0] {
    ACT_HOLD,
    ACT_WRITE,
    ACT_TICK,
    ACT_SOF_LOAD,
    ACT_SOF_STEP
  } ufi_act_e;
endpackage

// File: rtl/ufi_write_gate.sv
module ufi_write_gate #(
  parameter int STRB_W = ufi_pkg::STRB_W
) (
  input  logic              wr_en,
  input  logic [STRB_W-1:0] wr_strb,
  input  logic              device_mode,
  input  logic              halted,
  input  logic              run,
  output logic              wr_accept
);
  logic full_word;
  logic host_idle;

  // only a whole-word write counts; partial strobes are dropped
  assign full_word = &wr_strb;
  assign host_idle = halted && !run;
  assign wr_accept = wr_en && full_word && host_idle && !device_mode;
endmodule

// File: rtl/ufi_list_window.sv
module ufi_list_window #(
  parameter int IDX_W  = ufi_pkg::IDX_W,
  parameter int UF_W   = ufi_pkg::UF_W,
  parameter int SIZE_W = ufi_pkg::SIZE_W,
  parameter int LIST_W = ufi_pkg::LIST_W
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [SIZE_W-1:0] list_size,
  output logic [LIST_W-1:0] list_index,
  output logic              at_wrap
);
  localparam int NUM_SIZES = 1 << SIZE_W;

  logic [LIST_W-1:0] mask_tbl [NUM_SIZES];
  logic [LIST_W-1:0] mask;
  logic [LIST_W-1:0] raw;

  // each size code halves the list, dropping one index bit from the top
  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_mask
    if (g < LIST_W) begin : g_live
      assign mask_tbl[g] = {LIST_W{1'b1}} >> g;
    end else begin : g_empty
      assign mask_tbl[g] = '0;
    end
  end

  assign mask       = mask_tbl[list_size];
  assign raw        = idx[UF_W +: LIST_W];
  assign list_index = raw & mask;
  assign at_wrap    = (list_index == mask) && (&idx[UF_W-1:0]);
endmodule

// File: rtl/ufi_next_state.sv
module ufi_next_state
  import ufi_pkg::*;
#(
  parameter int IDX_W   = ufi_pkg::IDX_W,
  parameter int UF_W    = ufi_pkg::UF_W,
  parameter int FRAME_W = ufi_pkg::FRAME_W
) (
  input  logic [IDX_W-1:0]   idx,
  input  logic               device_mode,
  input  logic               run,
  input  logic               uframe_tick,
  input  logic               sof_valid,
  input  logic [FRAME_W-1:0] sof_frame,
  input  logic               wr_accept,
  input  logic [IDX_W-1:0]   wr_value,
  output logic [IDX_W-1:0]   idx_next,
  output logic               advance
);
  ufi_act_e act;
  logic     frame_same;

  assign frame_same = (idx[IDX_W-1:UF_W] == sof_frame);

  always_comb begin
    act = ACT_HOLD;
    if (device_mode) begin
      if (sof_valid) act = frame_same ? ACT_SOF_STEP : ACT_SOF_LOAD;
    end else if (wr_accept) begin
      act = ACT_WRITE;
    end else if (run && uframe_tick) begin
      act = ACT_TICK;
    end
  end

  always_comb begin
    idx_next = idx;
    unique case (act)
      ACT_WRITE:    idx_next = wr_value;
      ACT_TICK:     idx_next = idx + IDX_W'(1);
      ACT_SOF_LOAD: idx_next = {sof_frame, {UF_W{1'b0}}};
      ACT_SOF_STEP: idx_next = {idx[IDX_W-1:UF_W], idx[UF_W-1:0] + UF_W'(1)};
      default:      idx_next = idx;
    endcase
  end

  assign advance = (act == ACT_TICK);
endmodule

// File: rtl/usb_frame_index.sv
module usb_frame_index
  import ufi_pkg::*;
#(
  parameter int IDX_W  = ufi_pkg::IDX_W,
  parameter int UF_W   = ufi_pkg::UF_W,
  parameter int SIZE_W = ufi_pkg::SIZE_W,
  parameter int LIST_W = ufi_pkg::LIST_W,
  parameter int BUS_W  = ufi_pkg::BUS_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   device_mode,
  input  logic                   run,
  input  logic                   halted,
  input  logic [SIZE_W-1:0]      list_size,
  input  logic                   uframe_tick,
  input  logic                   sof_valid,
  input  logic [IDX_W-UF_W-1:0]  sof_frame,
  input  logic                   wr_en,
  input  logic [BUS_W/8-1:0]     wr_strb,
  input  logic [BUS_W-1:0]       wr_data,
  output logic [IDX_W-1:0]       frindex,
  output logic [LIST_W-1:0]      list_index,
  output logic                   rollover,
  output logic [IDX_W-UF_W-1:0]  sof_frame_out
);
  localparam int FRAME_W = IDX_W - UF_W;
  localparam int STRB_W  = BUS_W / 8;

  logic             wr_accept;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_next;
  logic             advance;
  logic             at_wrap;
  logic             roll_q;

  ufi_write_gate #(.STRB_W(STRB_W)) u_gate (
    .wr_en       (wr_en),
    .wr_strb     (wr_strb),
    .device_mode (device_mode),
    .halted      (halted),
    .run         (run),
    .wr_accept   (wr_accept)
  );

  ufi_next_state #(.IDX_W(IDX_W), .UF_W(UF_W), .FRAME_W(FRAME_W)) u_next (
    .idx         (idx_q),
    .device_mode (device_mode),
    .run         (run),
    .uframe_tick (uframe_tick),
    .sof_valid   (sof_valid),
    .sof_frame   (sof_frame),
    .wr_accept   (wr_accept),
    .wr_value    (wr_data[IDX_W-1:0]),
    .idx_next    (idx_next),
    .advance     (advance)
  );

  ufi_list_window #(.IDX_W(IDX_W), .UF_W(UF_W), .SIZE_W(SIZE_W), .LIST_W(LIST_W)) u_win (
    .idx        (idx_q),
    .list_size  (list_size),
    .list_index (list_index),
    .at_wrap    (at_wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      roll_q <= 1'b0;
    end else begin
      idx_q  <= idx_next;
      roll_q <= advance && at_wrap;
    end
  end

  assign frindex       = idx_q;
  assign rollover      = roll_q;
  assign sof_frame_out = idx_q[IDX_W-1:UF_W];
endmodule

// File: rtl/usb_frame_index_chk.sv
module usb_frame_index_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        device_mode,
  input logic        run,
  input logic        halted,
  input logic [2:0]  list_size,
  input logic        uframe_tick,
  input logic        sof_valid,
  input logic [10:0] sof_frame,
  input logic        wr_en,
  input logic [3:0]  wr_strb,
  input logic [31:0] wr_data,
  input logic [13:0] frindex,
  input logic [9:0]  list_index,
  input logic        rollover
);
  logic [4:0] drop_bits;
  assign drop_bits = 5'd10 - {2'b00, list_size};

  assert_tick_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!device_mode && run && uframe_tick) |=> frindex == $past(frindex) + 14'd1);

  assert_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (list_index >> drop_bits) == 10'd0);

  assert_rollover_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rollover |-> ($past(uframe_tick) && $past(run) && !$past(device_mode) && frindex[2:0] == 3'd0));

  assert_write_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!device_mode && wr_en && wr_strb == 4'hF && halted && !run) |=> frindex == $past(wr_data[13:0]));

  assert_blocked_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!device_mode && wr_en && !halted && !run) |=> $stable(frindex));

  assert_partial_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!device_mode && wr_en && wr_strb != 4'hF && !run) |=> $stable(frindex));

  assert_device_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (device_mode && !sof_valid) |=> $stable(frindex));

  assert_sof_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (device_mode && sof_valid && sof_frame != frindex[13:3]) |=> frindex == {$past(sof_frame), 3'b000});

  assert_sof_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (device_mode && sof_valid && sof_frame == frindex[13:3]) |=>
      (frindex[13:3] == $past(frindex[13:3]) && frindex[2:0] == $past(frindex[2:0]) + 3'd1));
endmodule

bind usb_frame_index usb_frame_index_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .device_mode (device_mode),
  .run         (run),
  .halted      (halted),
  .list_size   (list_size),
  .uframe_tick (uframe_tick),
  .sof_valid   (sof_valid),
  .sof_frame   (sof_frame),
  .wr_en       (wr_en),
  .wr_strb     (wr_strb),
  .wr_data     (wr_data),
  .frindex     (frindex),
  .list_index  (list_index),
  .rollover    (rollover)
);

// File: tb/usb_frame_index_tb.sv
module usb_frame_index_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        device_mode, run, halted, uframe_tick, sof_valid, wr_en;
  logic [2:0]  list_size;
  logic [10:0] sof_frame;
  logic [3:0]  wr_strb;
  logic [31:0] wr_data;
  logic [13:0] frindex;
  logic [9:0]  list_index;
  logic        rollover;
  logic [10:0] sof_frame_out;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  logic [13:0] exp_idx;
  logic        exp_roll;
  string       exp_tag;
  bit          finished = 0;

  always #5 clk = ~clk;

  usb_frame_index u_dut (
    .clk(clk), .rst_n(rst_n), .device_mode(device_mode), .run(run), .halted(halted),
    .list_size(list_size), .uframe_tick(uframe_tick), .sof_valid(sof_valid),
    .sof_frame(sof_frame), .wr_en(wr_en), .wr_strb(wr_strb), .wr_data(wr_data),
    .frindex(frindex), .list_index(list_index), .rollover(rollover),
    .sof_frame_out(sof_frame_out)
  );

  function automatic logic [9:0] win_mask(input logic [2:0] sz);
    return 10'h3FF >> sz;
  endfunction

  function automatic logic [9:0] exp_list(input logic [13:0] v, input logic [2:0] sz);
    return (v >> 3) & win_mask(sz);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model of one clock edge using the inputs currently driven
  task automatic model_step();
    exp_roll = 1'b0;
    if (device_mode) begin
      if (sof_valid) begin
        if (exp_idx[13:3] != sof_frame) begin
          exp_idx = {sof_frame, 3'b000}; exp_tag = "R9";
        end else begin
          exp_idx[2:0] = exp_idx[2:0] + 3'd1; exp_tag = "R10";
        end
      end else exp_tag = "R8";
    end else if (wr_en && wr_strb == 4'hF && halted && !run) begin
      exp_idx = wr_data[13:0]; exp_tag = "R5";
    end else if (run && uframe_tick) begin
      exp_roll = (exp_list(exp_idx, list_size) == win_mask(list_size)) && (exp_idx[2:0] == 3'd7);
      exp_idx  = exp_idx + 14'd1; exp_tag = "R2";
    end else if (wr_en && wr_strb != 4'hF) exp_tag = "R7";
    else if (wr_en) exp_tag = "R6";
    else exp_tag = "R12";
  endtask

  task automatic cycle_and_check();
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(exp_tag, 32'(frindex), 32'(exp_idx));
    check("R3", 32'(list_index), 32'(exp_list(exp_idx, list_size)));
    check("R4", 32'(rollover), 32'(exp_roll));
    check("R11", 32'(sof_frame_out), 32'(exp_idx[13:3]));
  endtask

  task automatic idle_inputs();
    device_mode = 0; run = 0; halted = 1; uframe_tick = 0; sof_valid = 0;
    sof_frame = '0; wr_en = 0; wr_strb = 4'hF; wr_data = '0; list_size = '0;
  endtask

  task automatic random_phase(input bit dev, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      device_mode = dev;
      run         = ($urandom_range(0, 9) < 7);
      halted      = ($urandom_range(0, 1) == 1);
      uframe_tick = ($urandom_range(0, 9) < 6);
      wr_en       = ($urandom_range(0, 9) < 2);
      wr_strb     = ($urandom_range(0, 9) < 7) ? 4'hF : 4'($urandom_range(0, 14));
      wr_data     = $urandom;
      list_size   = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7)) : 3'd7;
      sof_valid   = ($urandom_range(0, 9) < 4);
      sof_frame   = ($urandom_range(0, 1) == 1) ? exp_idx[13:3] : 11'($urandom);
      cycle_and_check();
    end
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0F1D));
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1", 32'(frindex), 0);
    check("R1", 32'(rollover), 0);
    rst_n = 1;
    exp_idx = '0;
    @(negedge clk);
    check("R1", 32'(frindex), 0);

    // R5 then R2/R4: write 0x1FFF, tick into 0x2000 with 1024 entries
    wr_en = 1; wr_data = 32'hFFFF_DFFF; cycle_and_check();
    check("R5", 32'(frindex), 32'h1FFF);
    wr_en = 0; halted = 0; run = 1; uframe_tick = 1; cycle_and_check();
    check("R4", 32'(rollover), 1);
    uframe_tick = 0; cycle_and_check();
    check("R4", 32'(rollover), 0);
    // R6: write while running ignored even with tick absent
    wr_en = 1; wr_data = 32'h0000_0123; cycle_and_check();
    check("R6", 32'(frindex), 32'h2000);
    // R7: partial strobe while halted ignored
    run = 0; halted = 1; wr_strb = 4'b0111; cycle_and_check();
    check("R7", 32'(frindex), 32'h2000);
    // R11: full write changes SOF frame output
    wr_strb = 4'hF; wr_data = 32'h0000_3FFF; cycle_and_check();
    check("R11", 32'(sof_frame_out), 32'h7FF);
    // R12: ticks ignored with run low, SOF ignored in host mode
    wr_en = 0; uframe_tick = 1; sof_valid = 1; sof_frame = 11'h005; cycle_and_check();
    check("R12", 32'(frindex), 32'h3FFF);
    // R2 wrap of the whole counter, size 8 entries -> R4
    sof_valid = 0; run = 1; halted = 0; list_size = 3'd7; cycle_and_check();
    check("R2", 32'(frindex), 0);
    check("R4", 32'(rollover), 1);
    // R3 across every size code
    run = 0; uframe_tick = 0; halted = 1; wr_en = 1; wr_data = 32'h0000_2AB8;
    cycle_and_check(); wr_en = 0;
    for (int s = 0; s < 8; s++) begin
      list_size = 3'(s);
      #1;
      check("R3", 32'(list_index), 32'(exp_list(14'h2AB8, 3'(s))));
    end

    // device mode: R9 reload, R10 step with wrap of bits [2:0], R8 hold
    device_mode = 1; sof_valid = 1; sof_frame = 11'h005; cycle_and_check();
    check("R9", 32'(frindex), 32'h0028);
    for (int k = 0; k < 8; k++) cycle_and_check();
    check("R10", 32'(frindex), 32'h0028);
    sof_valid = 0; wr_en = 1; wr_data = 32'h0000_1111; uframe_tick = 1; run = 1;
    cycle_and_check();
    check("R8", 32'(frindex), 32'h0028);

    // random phases
    random_phase(0, 3000);
    random_phase(1, 1500);
    random_phase(0, 3000);
    random_phase(1, 1000);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule